// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the two low-power states of a small microcontroller core. Software writes a two-bit power control field. One bit asks for a light sleep, in which only the CPU clock stops. The other bit asks for a deep sleep, in which the oscillator itself stops. The block drives enable signals for the CPU clock gate, the peripheral clock gate and the oscillator. It also drives a write enable for the CPU-side storage ports, so RAM and special-function registers keep their contents while the CPU is parked. A status field reports the current mode.

Two events end a low-power state. An enabled, pending interrupt ends light sleep. A qualified reset from the external reset pin ends either state. The pin is sampled once per machine cycle, which is a fixed number of oscillator clocks. A reset is accepted only after the pin has been seen high on two consecutive samples. In deep sleep no machine cycles are counted, so a high pin drives the internal reset straight away. On the next clock the oscillator is enabled again.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_n` is sampled low, the block is in run mode. `cpu_clk_en`, `per_clk_en`, `osc_en` and `cpu_wr_en` are 1, `mode_stat` is 2'b00 and `core_rst` is 0.
- R2: In run mode, a write with `ctrl_wdata[0]`=1 and `ctrl_wdata[1]`=0 enters light sleep from the next clock. `cpu_clk_en` and `cpu_wr_en` drop to 0 and `mode_stat` becomes 2'b01 (bit 0 = light sleep).
- R3: In light sleep, `per_clk_en` and `osc_en` stay 1.
- R4: In light sleep, `irq_pend` returns the block to run mode only at a machine-cycle boundary. The boundary is the clock edge that ends each group of `MC_CLKS` running clocks. After that edge `cpu_clk_en` and `cpu_wr_en` are 1 and `mode_stat` is 2'b00.
- R5: In run mode, a write with `ctrl_wdata[1]`=1 enters deep sleep from the next clock, whatever the value of bit 0. In deep sleep all four enables are 0 and `mode_stat` is 2'b10 (bit 1 = deep sleep).
- R6: In deep sleep, `irq_pend` and `ctrl_wr` have no effect. The block stays in deep sleep until a reset.
- R7: Outside deep sleep, `rst_pin` is sampled only at machine-cycle boundaries. `core_rst` rises after the second of two consecutive high samples and falls after the first low sample. A single high sample has no effect.
- R8: A qualified reset returns the block from light sleep to run mode. It wins over a pending interrupt on the same edge.
- R9: In deep sleep, `rst_pin`=1 drives `core_rst` to 1 in the same cycle. At the next clock the block is in run mode with `osc_en`=1. `core_rst` then stays 1 until the first low sample at a machine-cycle boundary.
- R10: Control writes are ignored while `core_rst` is 1 and while in light sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ctrl_wr | input | 1 | Write strobe for the power control field |
| ctrl_wdata | input | 2 | Write data: bit 0 light sleep, bit 1 deep sleep |
| irq_pend | input | 1 | An enabled interrupt is pending |
| rst_pin | input | 1 | External reset pin level |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| cpu_wr_en | output | 1 | Write enable for CPU-side RAM and register ports |
| core_rst | output | 1 | Qualified internal reset |
| mode_stat | output | 2 | Current mode: bit 0 light sleep, bit 1 deep sleep |

## Verification
A wrong mode state appears on the clock enables and the status in the cycle right after the faulty edge. A machine-cycle counter that drifts is harder to see. It only shows when an interrupt wake-up or a reset sample lands one or more clocks away from the expected boundary. The reset qualifier shows a wrong count only on `core_rst`, and only after a pin pulse of one or two machine cycles. For these reasons the bench compares every output on every clock against a behavioural model. It also uses pin pulses whose lengths sit around the one-sample and two-sample limits.

// File: rtl/pmc_pkg.sv
// Package: shared mode encoding and control field bit positions for
// the low-power mode controller.
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pm_mode_e;

    localparam int CTRL_IDLE_BIT = 0;
    localparam int CTRL_DOWN_BIT = 1;
endpackage

// File: rtl/pmc_tick.sv
// Machine-cycle timer. Counts MC_CLKS oscillator clocks while the
// oscillator is enabled and flags the last clock of each group.
// Assumes MC_CLKS >= 2. The count freezes while run_en is low.
module pmc_tick #(
    parameter int MC_CLKS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic mc_tick
);
    localparam int CW = $clog2(MC_CLKS);
    localparam logic [CW-1:0] LAST = CW'(MC_CLKS - 1);

    logic [CW-1:0] cnt;

    // Advance the phase counter while the oscillator runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run_en)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Boundary flag on the final clock of a machine cycle.
    always_comb mc_tick = run_en && (cnt == LAST);

    assert_count_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(cnt));
    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/pmc_rst_qual.sv
// Reset pin qualifier. Samples the pin on each machine-cycle tick.
// Asserts the qualified reset after HOLD_SAMPLES consecutive high
// samples and clears it on the first low sample. preload forces the
// qualified state at once (used on wake from deep sleep).
module pmc_rst_qual #(
    parameter int HOLD_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic pin,
    input  logic preload,
    output logic qual
);
    localparam int SW = $clog2(HOLD_SAMPLES + 1);
    localparam logic [SW-1:0] FULL = SW'(HOLD_SAMPLES);

    logic [SW-1:0] seen;

    // Count consecutive high samples, saturating at FULL.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= '0;
        else if (preload)
            seen <= FULL;
        else if (mc_tick)
            seen <= !pin ? '0 : ((seen == FULL) ? FULL : seen + 1'b1);
    end

    // Qualified once the full run of samples has been seen.
    always_comb qual = (seen == FULL);

    assert_release_on_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_tick && !pin && !preload) |=> !qual);
    assert_no_single_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == '0 && !preload) |=> !qual);
    assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !preload) |=> $stable(qual));
endmodule

// File: rtl/pmc_mode_fsm.sv
// Mode state machine. Holds run, light-sleep or deep-sleep state.
// Assumes core_rst already includes the fast deep-sleep path. A
// qualified reset wins over every other event.
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_wdata,
    input  logic       irq_pend,
    input  logic       mc_tick,
    input  logic       core_rst,
    output pm_mode_e   mode
);
    pm_mode_e mode_nxt;

    // Next-state selection: reset, deep sleep over light sleep, wake on boundary.
    always_comb begin
        mode_nxt = mode;
        if (core_rst) begin
            mode_nxt = PM_RUN;
        end else begin
            case (mode)
                PM_RUN: begin
                    if (ctrl_wr && ctrl_wdata[CTRL_DOWN_BIT])
                        mode_nxt = PM_DOWN;
                    else if (ctrl_wr && ctrl_wdata[CTRL_IDLE_BIT])
                        mode_nxt = PM_IDLE;
                end
                PM_IDLE: if (irq_pend && mc_tick) mode_nxt = PM_RUN;
                default: mode_nxt = mode;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= PM_RUN;
        else
            mode <= mode_nxt;
    end

    assert_down_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_RUN && ctrl_wr && ctrl_wdata[CTRL_DOWN_BIT] && !core_rst) |=> mode == PM_DOWN);
    assert_wake_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_IDLE && !mc_tick && !core_rst) |=> mode == PM_IDLE);
    assert_down_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_DOWN && !core_rst) |=> mode == PM_DOWN);
    assert_reset_to_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> mode == PM_RUN);
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Low-power mode controller top. Combines the machine-cycle timer,
// the reset qualifier and the mode state machine. It drives clock,
// oscillator and storage-write enables. In deep sleep a high reset
// pin bypasses the sample counter, because no ticks are produced there.
module pwr_mode_ctrl #(
    parameter int MC_CLKS      = 12,
    parameter int HOLD_SAMPLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_wdata,
    input  logic       irq_pend,
    input  logic       rst_pin,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       cpu_wr_en,
    output logic       core_rst,
    output logic [1:0] mode_stat
);
    import pmc_pkg::*;

    pm_mode_e mode;
    logic     mc_tick;
    logic     rst_qual;
    logic     fast_rst;

    // Oscillator runs except in deep sleep.
    always_comb osc_en = (mode != PM_DOWN);

    pmc_tick #(.MC_CLKS(MC_CLKS)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (osc_en),
        .mc_tick (mc_tick)
    );

    // Direct reset path while the oscillator is stopped.
    always_comb fast_rst = (mode == PM_DOWN) && rst_pin;

    pmc_rst_qual #(.HOLD_SAMPLES(HOLD_SAMPLES)) i_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .mc_tick (mc_tick),
        .pin     (rst_pin),
        .preload (fast_rst),
        .qual    (rst_qual)
    );

    // Internal reset from either the qualified or the fast path.
    always_comb core_rst = rst_qual || fast_rst;

    pmc_mode_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .irq_pend   (irq_pend),
        .mc_tick    (mc_tick),
        .core_rst   (core_rst),
        .mode       (mode)
    );

    // Gate enables and status decoded from the mode.
    always_comb begin
        cpu_clk_en = (mode == PM_RUN);
        cpu_wr_en  = (mode == PM_RUN);
        per_clk_en = (mode != PM_DOWN);
        mode_stat  = {mode == PM_DOWN, mode == PM_IDLE};
    end

    assert_fast_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat[1] && rst_pin) |=> (osc_en && core_rst));
    assert_periph_in_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_stat[0]) |-> (per_clk_en && osc_en && !cpu_clk_en));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    localparam int MC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [1:0] ctrl_wdata = 2'b00;
    logic       irq_pend = 1'b0;
    logic       rst_pin = 1'b0;
    logic       cpu_clk_en, per_clk_en, osc_en, cpu_wr_en, core_rst;
    logic [1:0] mode_stat;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string phase = "R1";
    bit started = 1'b0;

    // Behavioural reference: 0 run, 1 light sleep, 2 deep sleep.
    int m_mode = 0;
    int m_phase = 0;
    int m_seen = 0;

    pwr_mode_ctrl #(.MC_CLKS(MC), .HOLD_SAMPLES(2)) i_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .irq_pend(irq_pend), .rst_pin(rst_pin), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .cpu_wr_en(cpu_wr_en),
        .core_rst(core_rst), .mode_stat(mode_stat)
    );

    always #5 clk = ~clk;

    function automatic bit m_core();
        return (m_seen >= 2) || (m_mode == 2 && rst_pin);
    endfunction

    always @(posedge clk) begin
        bit tick, core, force_q;
        int nmode;
        started = 1'b1;
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_phase = 0; m_seen = 0;
        end else begin
            tick = (m_mode != 2) && (m_phase == MC - 1);
            core = m_core();
            force_q = (m_mode == 2) && rst_pin;
            nmode = m_mode;
            if (core) nmode = 0;
            else if (m_mode == 0 && ctrl_wr && ctrl_wdata[1]) nmode = 2;
            else if (m_mode == 0 && ctrl_wr && ctrl_wdata[0]) nmode = 1;
            else if (m_mode == 1 && irq_pend && tick) nmode = 0;
            if (force_q) m_seen = 2;
            else if (tick) m_seen = rst_pin ? ((m_seen >= 2) ? 2 : m_seen + 1) : 0;
            if (m_mode != 2) m_phase = (m_phase == MC - 1) ? 0 : m_phase + 1;
            m_mode = nmode;
        end
    end

    task automatic chk(string what, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", phase, what, act, exp, $time);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk("cpu_clk_en", {1'b0, cpu_clk_en}, {1'b0, m_mode == 0});
            chk("cpu_wr_en",  {1'b0, cpu_wr_en},  {1'b0, m_mode == 0});
            chk("per_clk_en", {1'b0, per_clk_en}, {1'b0, m_mode != 2});
            chk("osc_en",     {1'b0, osc_en},     {1'b0, m_mode != 2});
            chk("core_rst",   {1'b0, core_rst},   {1'b0, m_core()});
            chk("mode_stat",  mode_stat, {m_mode == 2, m_mode == 1});
        end
    end

    task automatic idle_for(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctrl(logic [1:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0; ctrl_wdata = 2'b00;
    endtask

    task automatic pin_pulse(int n);
        @(negedge clk); rst_pin = 1'b1;
        idle_for(n);
        rst_pin = 1'b0;
        idle_for(4 * MC);
    endtask

    always @(posedge clk) begin
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        phase = "R1";
        idle_for(3);
        rst_n = 1'b1;
        idle_for(5);
        // R2 / R3: light sleep keeps peripherals and oscillator.
        phase = "R2"; write_ctrl(2'b01);
        phase = "R3"; idle_for(20);
        // R10: write while in light sleep is ignored.
        phase = "R10"; write_ctrl(2'b10); idle_for(5);
        // R4: interrupt wake on machine-cycle boundary.
        phase = "R4"; @(negedge clk); irq_pend = 1'b1; idle_for(2 * MC); irq_pend = 1'b0;
        idle_for(5);
        // R5: both bits set, deep sleep wins.
        phase = "R5"; write_ctrl(2'b11); idle_for(30);
        // R6: interrupt and writes ignored in deep sleep.
        phase = "R6"; @(negedge clk); irq_pend = 1'b1; write_ctrl(2'b01); idle_for(3 * MC);
        irq_pend = 1'b0; idle_for(5);
        // R9: fast reset from deep sleep, held to first low sample.
        phase = "R9"; pin_pulse(3 * MC + 5);
        // R7: pulses around one and two samples, from several phases.
        phase = "R7";
        pin_pulse(5);
        pin_pulse(MC);
        pin_pulse(MC + 3);
        pin_pulse(2 * MC + 1);
        pin_pulse(3 * MC);
        // R8: reset and interrupt together in light sleep.
        phase = "R8"; write_ctrl(2'b01); idle_for(7);
        @(negedge clk); irq_pend = 1'b1; rst_pin = 1'b1;
        idle_for(3 * MC); rst_pin = 1'b0; irq_pend = 1'b0; idle_for(3 * MC);
        // R10: write while reset is qualified is ignored.
        phase = "R10"; @(negedge clk); rst_pin = 1'b1; idle_for(3 * MC);
        write_ctrl(2'b10); rst_pin = 1'b0; idle_for(3 * MC);
        // R1: power-on reset from deep sleep.
        phase = "R5"; write_ctrl(2'b10); idle_for(10);
        phase = "R1"; @(negedge clk); rst_n = 1'b0; idle_for(3); rst_n = 1'b1; idle_for(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule